// File: doc/BRIEF.md
# Power-Management Companion Register Bank

This block is the register file of a power-management companion device. A host reaches it through a single-cycle register port. Each access carries a 5-bit index, a write strobe and 16-bit write data. Read data is combinational from the current state of the addressed register. The bank holds:

- an interrupt status word with a mask, driving a level interrupt output;
- an ADC channel selector backed by a per-channel result table that is loaded at reset;
- two general control words and a calibration word;
- a clear-on-write sample-control word;
- a power status word that follows a power-key input;
- a watchdog index whose zero write can request a system shutdown.

Several writes have side effects beyond storing data. A write to the interrupt-ID index flips status bits rather than storing them. A write to the ADC index picks a channel and immediately reports a finished sample as an interrupt. A zero write to the watchdog raises the shutdown request only when a control bit allows it. Indices with no function read as zero and drop writes.

Top module: `pmic_regbank`

## Requirements
- R1: After reset:
  - `irq_o` and `shutdown_o` are low.
  - Index 0x00 reads 0x0215, with bit 7 also set when parameter ALT_VARIANT is 1.
  - The mask (0x02) reads 0xFFFF and the interrupt status (0x01) reads 0x0000.
  - The power status (0x16) reads 0x0020 and the calibration word (0x06) reads 0x0001.
- R2: `irq_o` is high exactly when some bit of (status AND NOT mask) is set. It reflects a register update from the clock edge that performs it.
- R3: A write to index 0x01 XORs the write data into the interrupt status. A read of 0x01 returns the status.
- R4: Index 0x02 is the read/write interrupt mask; a mask bit of 1 blocks that status bit from `irq_o`.
- R5: A read of index 0x08 returns the selected channel in bits [13:10], ORed with that channel's 10-bit result in bits [9:0]. The result table is:
  - 1: 0x3C2, 2: 0x0FC, 3: 0x165, 4: 0x07B, 5: 0x3FF;
  - 6: 0x011, 7: 0x011, 8: 0x250, 10: 0x002, 11: 0x011;
  - 12: 0x3D0, 13: 0x330;
  - every other channel: 0.
  The channel resets to 0.
- R6: A write to index 0x08 takes the channel from write-data bits [13:10], ignores the other bits, and sets status bit 8.
- R7: A write to index 0x09 clears every sample-control bit that is 1 in the write data. The word resets to 0.
- R8: A write of 0x0000 to index 0x17 while bit 1 of control word 1 (index 0x0D) is set raises `shutdown_o`. `shutdown_o` then stays high until reset. A nonzero watchdog write, or a zero write with that bit clear, leaves `shutdown_o` low.
- R9: A power-key event pulse (`key_evt_i`) sets status bit 0. It also loads power-status bit 5 with the inverse of `key_down_i`: 0 while pressed, 1 when released.
- R10: Control word 1 (0x0D), control word 2 (0x0E) and calibration (0x06) read back the last value written.
- R11: Indices with no function (for example 0x03, 0x1A) and the watchdog index 0x17 read as 0x0000, and writes to them change no readable state.
- R12: When a status-bit set (key event or ADC write) coincides with an XOR write to 0x01, the set wins for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 5 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed register |
| key_evt_i | input | 1 | One-cycle power-key event pulse |
| key_down_i | input | 1 | Key state sampled with the event (1 = pressed) |
| irq_o | output | 1 | Interrupt request |
| shutdown_o | output | 1 | Sticky shutdown request |

## Verification
The bench targets the following corner cases:

- **Interrupt-ID toggle.** It writes a bit that is already set to 0x01. A design that stored the data instead of XORing it would keep or clear the wrong bits.
- **Mask walk.** It moves the mask across pending bits. An inverted mask would raise `irq_o` while every source is masked.
- **ADC data bits.** It writes ADC data with junk in the low bits, selects unused channels 9 and 15, and re-reads status bit 8. A design that stored the whole word, or dropped the done flag, shows the wrong read value.
- **Coincident set and clear.** It pulses a key event in the same cycle as a clearing XOR. A design that let the XOR win loses the key interrupt.
- **Watchdog gating.** It writes zero to the watchdog with the enable bit clear, writes a nonzero value with the bit set, and finally writes zero with the bit set. It then clears the enable to confirm the request does not fall away.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
  localparam int DW  = 16;
  localparam int AW  = 5;
  localparam int CHW = 4;
  localparam int RESW = 10;

  localparam logic [AW-1:0] IDX_CHIP_ID  = 5'h00;
  localparam logic [AW-1:0] IDX_IRQ_ST   = 5'h01;
  localparam logic [AW-1:0] IDX_IRQ_MASK = 5'h02;
  localparam logic [AW-1:0] IDX_CAL      = 5'h06;
  localparam logic [AW-1:0] IDX_ADC      = 5'h08;
  localparam logic [AW-1:0] IDX_SAMPLE   = 5'h09;
  localparam logic [AW-1:0] IDX_CTRL1    = 5'h0D;
  localparam logic [AW-1:0] IDX_CTRL2    = 5'h0E;
  localparam logic [AW-1:0] IDX_PWR_ST   = 5'h16;
  localparam logic [AW-1:0] IDX_WDOG     = 5'h17;

  localparam logic [DW-1:0] CHIP_ID_BASE = 16'h0215;
  localparam int            ALT_ID_BIT   = 7;
  localparam int            KEY_IRQ_BIT  = 0;
  localparam int            ADC_IRQ_BIT  = 8;
  localparam int            KEY_ST_BIT   = 5;
  localparam int            WDOG_EN_BIT  = 1;

  function automatic logic [RESW-1:0] adc_preset(input int ch);
    case (ch)
      1:       return 10'h3C2;
      2:       return 10'h0FC;
      3:       return 10'h165;
      4:       return 10'h07B;
      5:       return 10'h3FF;
      6:       return 10'h011;
      7:       return 10'h011;
      8:       return 10'h250;
      10:      return 10'h002;
      11:      return 10'h011;
      12:      return 10'h3D0;
      13:      return 10'h330;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pmic_irq_ctrl.sv
module pmic_irq_ctrl #(
  parameter int NSRC    = 16,
  parameter int ADC_BIT = 8,
  parameter int KEY_BIT = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            xor_we_i,
  input  logic            mask_we_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic            adc_set_i,
  input  logic            key_set_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic [NSRC-1:0] status_q, mask_q, set_vec, flip_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[ADC_BIT] = adc_set_i;
    set_vec[KEY_BIT] = key_set_i;
    flip_vec         = xor_we_i ? wdata_i : '0;
  end

  // sets applied after the flip so a coincident event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q ^ flip_vec) | set_vec;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  // R3
  status_xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xor_we_i && !adc_set_i && !key_set_i) |=> status_q == $past(status_q ^ wdata_i));
  // R6
  adc_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_set_i |=> status_q[ADC_BIT]);
  // R12
  key_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_set_i |=> status_q[KEY_BIT]);
  // R4
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_q == $past(wdata_i));
  // R2
  all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
endmodule

// File: rtl/pmic_adc_unit.sv
module pmic_adc_unit
  import pmic_pkg::*;
#(
  parameter int CH_W  = CHW,
  parameter int RES_W = RESW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_we_i,
  input  logic [CH_W-1:0] sel_i,
  output logic [CH_W-1:0] chan_o,
  output logic [RES_W-1:0] result_o
);
  localparam int NCH = 1 << CH_W;

  logic [CH_W-1:0]  chan_q;
  logic [RES_W-1:0] tbl_q [NCH];

  // result table loaded at reset, never written afterwards
  for (genvar g = 0; g < NCH; g++) begin : g_tbl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_q[g] <= adc_preset(g);
      else         tbl_q[g] <= tbl_q[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       chan_q <= '0;
    else if (sel_we_i) chan_q <= sel_i;
  end

  assign chan_o   = chan_q;
  assign result_o = tbl_q[chan_q];

  // R6
  chan_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> chan_o == $past(sel_i));
  // R6
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(chan_o));
endmodule

// File: rtl/pmic_ctrl_regs.sv
module pmic_ctrl_regs
  import pmic_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          key_evt_i,
  input  logic          key_down_i,
  output logic [DW-1:0] ctrl1_o,
  output logic [DW-1:0] ctrl2_o,
  output logic [DW-1:0] cal_o,
  output logic [DW-1:0] sample_o,
  output logic [DW-1:0] pwr_st_o,
  output logic          shutdown_o
);
  logic [DW-1:0] ctrl1_q, ctrl2_q, cal_q, sample_q;
  logic          key_up_q, shut_q, wdog_fire;

  assign wdog_fire = wr_en_i && (addr_i == IDX_WDOG) && (wdata_i == '0)
                     && ctrl1_q[WDOG_EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl1_q  <= '0;
      ctrl2_q  <= '0;
      cal_q    <= 16'h0001;
      sample_q <= '0;
      key_up_q <= 1'b1;
      shut_q   <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == IDX_CTRL1)  ctrl1_q  <= wdata_i;
      if (wr_en_i && addr_i == IDX_CTRL2)  ctrl2_q  <= wdata_i;
      if (wr_en_i && addr_i == IDX_CAL)    cal_q    <= wdata_i;
      if (wr_en_i && addr_i == IDX_SAMPLE) sample_q <= sample_q & ~wdata_i;
      if (key_evt_i) key_up_q <= ~key_down_i;
      if (wdog_fire) shut_q <= 1'b1;
    end
  end

  always_comb begin
    pwr_st_o             = '0;
    pwr_st_o[KEY_ST_BIT] = key_up_q;
  end

  assign ctrl1_o    = ctrl1_q;
  assign ctrl2_o    = ctrl2_q;
  assign cal_o      = cal_q;
  assign sample_o   = sample_q;
  assign shutdown_o = shut_q;

  // R8
  shutdown_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> $past(wr_en_i && addr_i == IDX_WDOG && wdata_i == '0
                                && ctrl1_o[WDOG_EN_BIT]));
  // R8
  shutdown_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> shutdown_o);
  // R9
  key_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_evt_i |=> pwr_st_o[KEY_ST_BIT] == !$past(key_down_i));
endmodule

// File: rtl/pmic_regbank.sv
module pmic_regbank
  import pmic_pkg::*;
#(
  parameter bit ALT_VARIANT = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          key_evt_i,
  input  logic          key_down_i,
  output logic          irq_o,
  output logic          shutdown_o
);
  localparam logic [DW-1:0] CHIP_ID =
    CHIP_ID_BASE | (DW'(ALT_VARIANT) << ALT_ID_BIT);
  localparam int CH_LO = 10;

  logic [DW-1:0]   status, mask, ctrl1, ctrl2, cal, sample, pwr_st;
  logic [CHW-1:0]  chan;
  logic [RESW-1:0] result;
  logic            wr_st, wr_mask, wr_adc;

  assign wr_st   = wr_en_i && addr_i == IDX_IRQ_ST;
  assign wr_mask = wr_en_i && addr_i == IDX_IRQ_MASK;
  assign wr_adc  = wr_en_i && addr_i == IDX_ADC;

  pmic_irq_ctrl #(
    .NSRC   (DW),
    .ADC_BIT(ADC_IRQ_BIT),
    .KEY_BIT(KEY_IRQ_BIT)
  ) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xor_we_i (wr_st),
    .mask_we_i(wr_mask),
    .wdata_i  (wdata_i),
    .adc_set_i(wr_adc),
    .key_set_i(key_evt_i),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  pmic_adc_unit #(
    .CH_W (CHW),
    .RES_W(RESW)
  ) u_adc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_we_i(wr_adc),
    .sel_i   (wdata_i[CH_LO+CHW-1:CH_LO]),
    .chan_o  (chan),
    .result_o(result)
  );

  pmic_ctrl_regs u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .key_evt_i (key_evt_i),
    .key_down_i(key_down_i),
    .ctrl1_o   (ctrl1),
    .ctrl2_o   (ctrl2),
    .cal_o     (cal),
    .sample_o  (sample),
    .pwr_st_o  (pwr_st),
    .shutdown_o(shutdown_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      IDX_CHIP_ID:  rdata_o = CHIP_ID;
      IDX_IRQ_ST:   rdata_o = status;
      IDX_IRQ_MASK: rdata_o = mask;
      IDX_CAL:      rdata_o = cal;
      IDX_ADC:      rdata_o = (DW'(chan) << CH_LO) | DW'(result);
      IDX_SAMPLE:   rdata_o = sample;
      IDX_CTRL1:    rdata_o = ctrl1;
      IDX_CTRL2:    rdata_o = ctrl2;
      IDX_PWR_ST:   rdata_o = pwr_st;
      default:      rdata_o = '0;
    endcase
  end

  // R11
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IDX_WDOG || addr_i == 5'h03 || addr_i == 5'h1A) |-> rdata_o == '0);
endmodule

// File: tb/pmic_regbank_tb.sv
`timescale 1ns/1ps
module pmic_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        key_evt = 1'b0;
  logic        key_down = 1'b0;
  logic [15:0] rdata;
  logic        irq, shutdown;

  always #2 clk = ~clk;

  pmic_regbank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .key_evt_i(key_evt),
    .key_down_i(key_down), .irq_o(irq), .shutdown_o(shutdown)
  );

  typedef struct {
    int          kind;  // 0 read data, 1 irq, 2 shutdown
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0, fails = 0;
  logic  probe = 1'b0;
  bit    done = 1'b0;

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic key(input logic down, input bit with_wr, input logic [15:0] d);
    @(negedge clk);
    key_evt = 1'b1; key_down = down;
    if (with_wr) begin wr_en = 1'b1; addr = 5'h01; wdata = d; end
    @(negedge clk);
    key_evt = 1'b0; wr_en = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [4:0] a,
                             input logic [15:0] e, input string tag);
    @(negedge clk);
    addr = a;
    q.push_back('{kind: kind, exp: e, tag: tag});
    probe = 1'b1;
    @(negedge clk);
    probe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
    expect_item(0, a, e, tag);
  endtask

  // monitor: pops one expected item per probed cycle
  always @(posedge clk) begin
    #1;
    if (probe && q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        1:       act = {15'd0, irq};
        2:       act = {15'd0, shutdown};
        default: act = rdata;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_item(1, 5'h00, 16'h0000, "R1 irq low");
    expect_item(2, 5'h00, 16'h0000, "R1 shutdown low");
    rd(5'h00, 16'h0215, "R1 chip id");
    rd(5'h02, 16'hFFFF, "R1 mask");
    rd(5'h01, 16'h0000, "R1 status");
    rd(5'h16, 16'h0020, "R1 power status");
    rd(5'h06, 16'h0001, "R1 cal");
    rd(5'h08, 16'h0000, "R5 adc reset channel 0");
    // R3 xor writes
    wr(5'h01, 16'h0005);
    rd(5'h01, 16'h0005, "R3 xor set");
    expect_item(1, 5'h00, 16'h0000, "R2 masked no irq");
    wr(5'h02, 16'hFFFE);
    rd(5'h02, 16'hFFFE, "R4 mask readback");
    expect_item(1, 5'h00, 16'h0001, "R2 unmasked irq");
    wr(5'h01, 16'h0001);
    rd(5'h01, 16'h0004, "R3 xor toggle clear");
    expect_item(1, 5'h00, 16'h0000, "R2 irq drops");
    wr(5'h02, 16'hFFFB);
    expect_item(1, 5'h00, 16'h0001, "R4 mask bit2 open");
    wr(5'h02, 16'hFFFF);
    expect_item(1, 5'h00, 16'h0000, "R4 all masked");
    // R5/R6 adc
    wr(5'h08, 16'h2000);
    rd(5'h01, 16'h0104, "R6 adc done bit8");
    rd(5'h08, 16'h2250, "R5 channel 8");
    wr(5'h08, 16'h1455);
    rd(5'h08, 16'h17FF, "R6 low bits ignored ch5");
    wr(5'h08, 16'h2400);
    rd(5'h08, 16'h2400, "R5 unused ch9");
    wr(5'h08, 16'h3C00);
    rd(5'h08, 16'h3C00, "R5 unused ch15");
    wr(5'h08, 16'h0400);
    rd(5'h08, 16'h07C2, "R5 channel 1");
    rd(5'h01, 16'h0104, "R6 bit8 still set");
    wr(5'h02, 16'hFEFF);
    expect_item(1, 5'h00, 16'h0001, "R2 adc irq");
    wr(5'h01, 16'h0100);
    rd(5'h01, 16'h0004, "R3 clear adc bit");
    expect_item(1, 5'h00, 16'h0000, "R2 adc irq cleared");
    // R9 power key
    key(1'b1, 1'b0, 16'h0000);
    rd(5'h16, 16'h0000, "R9 key pressed");
    rd(5'h01, 16'h0005, "R9 key irq bit0");
    key(1'b0, 1'b0, 16'h0000);
    rd(5'h16, 16'h0020, "R9 key released");
    // R12 coincident set wins over xor clear
    key(1'b0, 1'b1, 16'h0001);
    rd(5'h01, 16'h0005, "R12 set wins");
    // R7 sample control
    wr(5'h09, 16'hFFFF);
    rd(5'h09, 16'h0000, "R7 sample cleared");
    // R10 control words
    wr(5'h06, 16'h00A5);
    rd(5'h06, 16'h00A5, "R10 cal");
    wr(5'h0E, 16'hBEEF);
    rd(5'h0E, 16'hBEEF, "R10 ctrl2");
    // R11 unused
    wr(5'h1A, 16'h1234);
    rd(5'h1A, 16'h0000, "R11 unused 0x1a");
    rd(5'h03, 16'h0000, "R11 unused 0x03");
    rd(5'h0E, 16'hBEEF, "R11 neighbours untouched");
    // R8 watchdog
    wr(5'h17, 16'h0000);
    expect_item(2, 5'h00, 16'h0000, "R8 zero write disabled");
    rd(5'h17, 16'h0000, "R11 watchdog reads zero");
    wr(5'h0D, 16'h0002);
    rd(5'h0D, 16'h0002, "R10 ctrl1");
    wr(5'h17, 16'h0005);
    expect_item(2, 5'h00, 16'h0000, "R8 nonzero write");
    wr(5'h17, 16'h0000);
    expect_item(2, 5'h00, 16'h0001, "R8 shutdown raised");
    wr(5'h0D, 16'h0000);
    expect_item(2, 5'h00, 16'h0001, "R8 shutdown sticky");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard items left actual=%0d expected=0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule